// File: doc/BRIEF.md
# Periodic Tick Timer with Selectable Prescaler

This block raises a periodic interrupt request from the system clock. Software programs one 16-bit control word. That word holds an 8-bit modulus and a prescaler select bit. The input clock passes through a fixed divide-by-4 stage and then an optional divide-by-512 stage. The result decrements a modulus counter. Each time that counter expires, the block emits a one-clock request pulse and reloads the counter.

A modulus of zero parks the block in its idle state, and no requests are produced. The control word can be read and written at any time through a small register port. The register is decoded at one address, which is set by a parameter. After reset the modulus is zero. The prescaler select takes the inverse of a strap input that is sampled while reset is asserted.

The controller has two states. `ST_IDLE` means the modulus is zero and the divider chain is held. `ST_RUN` means the chain is counting. A register write with a nonzero modulus takes the block from `ST_IDLE` to `ST_RUN`. A write with a zero modulus takes it from `ST_RUN` to `ST_IDLE`. Any other write stays in `ST_RUN` and restarts the period.

Top module: `periodic_tick_timer`

## Requirements
- R1: While reset is asserted, the modulus becomes 0, the prescaler select (bit 8) becomes the inverse of `mode_strap`, and `tick_irq` is low.
- R2: Reading at `REG_ADDR` returns the modulus in bits 7:0 and the prescaler select in bit 8. Bits 15:9 always read 0, and writes to them are ignored.
- R3: With the prescaler select at 0, the first `tick_irq` pulse appears 4×M clock edges after the write edge, where M is the modulus.
- R4: With the prescaler select at 1, the period becomes 4×512×M clocks.
- R5: Each `tick_irq` pulse lasts exactly one clock.
- R6: On expiry the counter reloads in the same cycle, so successive pulses are exactly one period apart.
- R7: A modulus of 0 produces no pulses. Writing 0 while the timer runs stops it at once.
- R8: Any write to the register clears the divider stages and reloads the counter, so the next pulse comes one full period after that write.
- R9: A write to any other address changes nothing, and a read at any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_strap | input | 1 | Strap level; its inverse becomes the prescaler select at reset |
| bus_addr | input | ADDR_W | Register port address |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| tick_irq | output | 1 | One-clock periodic interrupt request |

## Verification
A write takes effect on the edge that samples it. The first request pulse is registered on the edge that lies exactly 4×M×P edges later. The bench therefore samples `tick_irq` on falling edges and counts falling edges from the write edge to the first pulse; the expected count is 4×M×P. After a pulse, the very next falling edge must show the pulse low, and the following pulse must arrive 4×M×P−1 falling edges later. Read data is combinational, so it is checked half a clock after the address is applied.

// File: rtl/periodic_timer_pkg.sv
package periodic_timer_pkg;
    localparam int REG_W     = 16;
    localparam int MOD_W     = 8;
    localparam int PRE_BIT   = 8;
    localparam int FIXED_DIV = 4;
    localparam int PRE_DIV   = 512;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pit_ctrl_reg.sv
module pit_ctrl_reg
    import periodic_timer_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              restart,
    output logic [MOD_W-1:0]  new_mod,
    output logic [MOD_W-1:0]  cur_mod,
    output logic              pre_sel
);
    localparam int RSV_W = REG_W - PRE_BIT - 1;

    logic hit;

    assign hit     = (bus_addr == REG_ADDR);
    assign restart = hit && bus_we;
    assign new_mod = bus_wdata[MOD_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_mod <= '0;
            pre_sel <= ~mode_strap;
        end else if (restart) begin
            cur_mod <= new_mod;
            pre_sel <= bus_wdata[PRE_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            bus_rdata = {{RSV_W{1'b0}}, pre_sel, cur_mod};
        end
    end

    // R2: reserved field never carries a one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[REG_W-1:PRE_BIT+1] == '0);

    // R9: a write elsewhere leaves the stored word untouched
    a_r9_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit) |=> ($stable(cur_mod) && $stable(pre_sel)));
endmodule

// File: rtl/pit_clock_chain.sv
module pit_clock_chain
    import periodic_timer_pkg::*;
#(
    parameter int FIX_DIV = FIXED_DIV,
    parameter int PRE_DV  = PRE_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic pre_sel,
    output logic step
);
    localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
    localparam int PW = (PRE_DV > 1) ? $clog2(PRE_DV) : 1;
    localparam logic [FW-1:0] F_LAST = FW'(FIX_DIV - 1);
    localparam logic [PW-1:0] P_LAST = PW'(PRE_DV - 1);

    logic          base_tick;
    logic [FW-1:0] base_cnt;
    logic [PW-1:0] pre_cnt;

    generate
        if (FIX_DIV > 1) begin : g_fixed
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    base_cnt <= '0;
                end else if (clear || !enable) begin
                    base_cnt <= '0;
                end else if (base_cnt == F_LAST) begin
                    base_cnt <= '0;
                end else begin
                    base_cnt <= base_cnt + 1'b1;
                end
            end
            assign base_tick = enable && (base_cnt == F_LAST);
        end else begin : g_nofixed
            assign base_cnt  = '0;
            assign base_tick = enable;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clear || !enable || !pre_sel) begin
            pre_cnt <= '0;
        end else if (base_tick) begin
            pre_cnt <= (pre_cnt == P_LAST) ? '0 : pre_cnt + 1'b1;
        end
    end

    assign step = base_tick && (!pre_sel || (pre_cnt == P_LAST));

    // R8: a restart empties both divider stages
    a_r8_chain_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (base_cnt == '0 && pre_cnt == '0));

    // R4: the prescaler only advances while selected
    a_r4_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_sel |=> (pre_cnt == '0));
endmodule

// File: rtl/pit_modulus_fsm.sv
module pit_modulus_fsm
    import periodic_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [MOD_W-1:0] new_mod,
    input  logic [MOD_W-1:0] cur_mod,
    input  logic             step,
    output logic             running,
    output logic             irq
);
    run_state_t       state_q, state_d;
    logic [MOD_W-1:0] cnt_q;
    logic             expire;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (restart && new_mod != '0) state_d = ST_RUN;
            ST_RUN:  if (restart && new_mod == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign expire = (state_q == ST_RUN) && step && (cnt_q == MOD_W'(1)) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= expire;
            if (restart) begin
                cnt_q <= new_mod;
            end else if (state_q == ST_RUN && step) begin
                cnt_q <= (cnt_q == MOD_W'(1)) ? cur_mod : cnt_q - 1'b1;
            end
        end
    end

    assign running = (state_q == ST_RUN);

    // R5: a request never spans two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: the idle state stays silent
    a_r7_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !irq);

    // R6: a running counter never holds zero
    a_r6_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (cnt_q != '0));

    // R8: a nonzero write loads the counter and enters the run state
    a_r8_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && new_mod != '0) |=> (cnt_q == $past(new_mod) && state_q == ST_RUN));
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
    import periodic_timer_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_strap,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              tick_irq
);
    logic             restart;
    logic             pre_sel;
    logic             running;
    logic             step;
    logic [MOD_W-1:0] new_mod;
    logic [MOD_W-1:0] cur_mod;

    pit_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_strap (mode_strap),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .restart    (restart),
        .new_mod    (new_mod),
        .cur_mod    (cur_mod),
        .pre_sel    (pre_sel)
    );

    pit_clock_chain #(
        .FIX_DIV (FIXED_DIV),
        .PRE_DV  (PRE_DIV)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .enable  (running),
        .pre_sel (pre_sel),
        .step    (step)
    );

    pit_modulus_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .new_mod (new_mod),
        .cur_mod (cur_mod),
        .step    (step),
        .running (running),
        .irq     (tick_irq)
    );

    // R1: no request while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !tick_irq);
endmodule

// File: tb/tb_periodic_tick_timer.sv
module tb_periodic_tick_timer;
    localparam logic [3:0] RA = 4'h4;
    localparam int NV = 6;
    // {prescale select, modulus}
    localparam logic [8:0] VEC [NV] = '{
        9'h001, 9'h002, 9'h005, 9'h0FF, 9'h101, 9'h102
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_strap = 1'b0;
    logic [3:0]  bus_addr = RA;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    periodic_tick_timer #(.ADDR_W(4), .REG_ADDR(RA)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_strap (mode_strap),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_irq   (tick_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        mode_strap = strap;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 irq in reset", int'(tick_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = RA;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = RA;
    endtask

    task automatic wait_pulse(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick_irq && n < limit);
        if (!tick_irq) n = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int n;
        int per;

        // R1: strap high gives select 0, strap low gives select 1, modulus 0
        do_reset(1'b1);
        reg_read(RA, rd);
        check("R1 reset word, strap=1", int'(rd), 16'h0000);
        do_reset(1'b0);
        reg_read(RA, rd);
        check("R1 reset word, strap=0", int'(rd), 16'h0100);
        wait_pulse(100, n);
        check("R7 no pulse after reset", n, -1);

        // Vector table: R3/R4 first pulse, R5 width, R6 period
        for (int i = 0; i < NV; i++) begin
            per = 4 * int'(VEC[i][7:0]) * (VEC[i][8] ? 512 : 1);
            reg_write(RA, {7'b0, VEC[i]});
            wait_pulse(per + 50, n);
            check(VEC[i][8] ? "R4 prescaled first pulse" : "R3 first pulse", n, per);
            @(negedge clk);
            check("R5 pulse width", int'(tick_irq), 0);
            wait_pulse(per + 50, n);
            check("R6 pulse spacing", n, per - 1);
        end

        // R2: reserved bits ignored and read as zero
        reg_write(RA, 16'hFE37);
        reg_read(RA, rd);
        check("R2 readback masked", int'(rd), 16'h0037);
        reg_write(RA, 16'hFFFF);
        reg_read(RA, rd);
        check("R2 readback all set", int'(rd), 16'h01FF);

        // R9: foreign address write ignored, foreign read zero
        reg_write(RA, 16'h0003);
        reg_write(4'h3, 16'h0105);
        reg_read(RA, rd);
        check("R9 register unchanged", int'(rd), 16'h0003);
        reg_read(4'h3, rd);
        check("R9 foreign read zero", int'(rd), 0);

        // R8: rewrite mid-period restarts full period (12 clocks)
        reg_write(RA, 16'h0003);
        repeat (7) @(negedge clk);
        reg_write(RA, 16'h0003);
        wait_pulse(100, n);
        check("R8 restart full period", n, 12);

        // R7: zero written while running stops output
        reg_write(RA, 16'h0002);
        repeat (5) @(negedge clk);
        reg_write(RA, 16'h0000);
        wait_pulse(300, n);
        check("R7 stopped by zero", n, -1);
        reg_write(RA, 16'h0100);
        wait_pulse(3000, n);
        check("R7 zero with prescale silent", n, -1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule